// File: doc/BRIEF.md
# Sweeping Phase Generator with Profile Banks

This block is the digital core of a direct synthesizer. It keeps a 32-bit phase register that advances once per clock by the current frequency. A sine stage turns the phase into a 10-bit amplitude code for a converter that sits outside the block. The current frequency starts at a tuning word. It can then be ramped automatically: a signed step is added at a programmable interval, and the result clamps at the ends of the range instead of wrapping.

Four profile banks each hold a tuning word and a phase offset. Two select pins choose which bank is in use. All settings, meaning the banks, the step, the interval and the ramp enable, are first written into shadow copies. An update strobe then moves every shadow copy into the working set in one clock, and the select pins are captured on the same edge. Two clear inputs restart the frequency ramp or zero the phase register.

Top module: `sweep_nco`

## Requirements
- R1: After reset, `cur_freq` is 0 and `amp_code` is 512 (mid-scale).
- R2: Shadow writes (`prof_we`, `ramp_we`) and changes of `prof_sel` have no visible effect until `fud` is high at a clock edge. On that edge every shadow value and `prof_sel` are taken over together.
- R3: On a `fud` edge, `cur_freq` loads the tuning word of the newly selected bank. A shadow write in the same cycle as `fud` lands only in the shadow copy and needs a later `fud` to take effect.
- R4: Each clock, the phase register adds `cur_freq` modulo 2^32. The upper 15 bits of the phase, bits [31:17], feed the sine stage.
- R5: The selected bank's 14-bit phase offset is added to the 15-bit phase at bit positions [14:1], modulo 2^15. An offset of 0x1000 is a quarter turn.
- R6: With the ramp enabled and an interval value N, `cur_freq` moves by the signed 32-bit step once every N+1 clocks. The first move comes N+1 clocks after a load.
- R7: A ramp clamps at 0 when going down and at 0xFFFFFFFF when going up, and never wraps.
- R8: `freq_clr` reloads `cur_freq` with the active tuning word and restarts the ramp interval.
- R9: `phase_clr` sets the phase register to 0 at that edge.
- R10: `amp_code` is registered and equals 512 + round(511·sin(2π·p/32768)) within ±2 codes, where p is the 15-bit offset phase. The top two bits of p pick the quadrant. Quadrant starts give exactly 512, 1023, 512 and 1.
- R11: With the ramp disabled and no load, `cur_freq` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_we | input | 1 | Write shadow copy of one bank |
| prof_idx | input | 2 | Bank written by `prof_we` |
| prof_ftw | input | 32 | Tuning word for the written bank |
| prof_poff | input | 14 | Phase offset for the written bank |
| ramp_we | input | 1 | Write shadow ramp settings |
| ramp_delta | input | 32 | Signed frequency step |
| ramp_rate | input | 16 | Interval value N (step every N+1 clocks) |
| ramp_en | input | 1 | Ramp enable |
| prof_sel | input | 2 | Bank select, captured on `fud` |
| fud | input | 1 | Update strobe |
| freq_clr | input | 1 | Restart frequency ramp |
| phase_clr | input | 1 | Zero the phase register |
| cur_freq | output | 32 | Current frequency word |
| amp_code | output | 10 | Offset-binary sine amplitude |

## Verification
A shadow write and the update strobe can land in the same cycle. The bench provokes this by rewriting the selected bank's tuning word together with `fud`. It then expects the old shadow value to load, and the new one to load only on a second strobe. A ramp step can also coincide with a load. Random runs fire `fud` and `freq_clr` at any point of the interval. A cycle-exact bench model judges these cases by giving the load priority and restarting the interval from zero.

// File: rtl/sweep_nco_pkg.sv
package sweep_nco_pkg;

  // Rational sine approximation over a quarter turn.
  // u in [0, n] maps to angle u/n * 90 degrees; result scaled to peak.
  function automatic int qsin_mag(input int u, input int n, input int peak);
    int v;
    int den;
    v   = u * (2 * n - u);
    den = 5 * n * n - v;
    return (4 * peak * v + den / 2) / den;
  endfunction

endpackage

// File: rtl/nco_prof_regs.sv
module nco_prof_regs #(
  parameter int NPROF = 4,
  parameter int FW    = 32,
  parameter int OW    = 14,
  parameter int RW    = 16,
  localparam int SW   = $clog2(NPROF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prof_we,
  input  logic [SW-1:0] prof_idx,
  input  logic [FW-1:0] prof_ftw,
  input  logic [OW-1:0] prof_poff,
  input  logic          ramp_we,
  input  logic [FW-1:0] ramp_delta,
  input  logic [RW-1:0] ramp_rate,
  input  logic          ramp_en,
  input  logic [SW-1:0] prof_sel,
  input  logic          fud,
  output logic [FW-1:0] load_ftw,
  output logic [OW-1:0] act_poff_sel,
  output logic [FW-1:0] act_delta,
  output logic [RW-1:0] act_rate,
  output logic          act_sweep,
  output logic [SW-1:0] act_sel
);

  logic [FW-1:0] stg_ftw  [NPROF];
  logic [OW-1:0] stg_poff [NPROF];
  logic [FW-1:0] act_ftw  [NPROF];
  logic [OW-1:0] act_poff [NPROF];

  logic [FW-1:0] stg_delta;
  logic [RW-1:0] stg_rate;
  logic          stg_sweep;

  for (genvar g = 0; g < NPROF; g++) begin : g_bank
    logic stg_ce;
    assign stg_ce = prof_we && (prof_idx == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_ftw[g]  <= '0;
        stg_poff[g] <= '0;
      end else if (stg_ce) begin
        stg_ftw[g]  <= prof_ftw;
        stg_poff[g] <= prof_poff;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_ftw[g]  <= '0;
        act_poff[g] <= '0;
      end else if (fud) begin
        act_ftw[g]  <= stg_ftw[g];
        act_poff[g] <= stg_poff[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_delta <= '0;
      stg_rate  <= '0;
      stg_sweep <= 1'b0;
    end else if (ramp_we) begin
      stg_delta <= ramp_delta;
      stg_rate  <= ramp_rate;
      stg_sweep <= ramp_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_delta <= '0;
      act_rate  <= '0;
      act_sweep <= 1'b0;
      act_sel   <= '0;
    end else if (fud) begin
      act_delta <= stg_delta;
      act_rate  <= stg_rate;
      act_sweep <= stg_sweep;
      act_sel   <= prof_sel;
    end
  end

  // Tuning word that is active after this edge.
  always_comb begin
    load_ftw     = fud ? stg_ftw[prof_sel] : act_ftw[act_sel];
    act_poff_sel = act_poff[act_sel];
  end

endmodule

// File: rtl/nco_freq_ramp.sv
module nco_freq_ramp #(
  parameter int FW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_ftw,
  input  logic          sweep,
  input  logic [FW-1:0] delta,
  input  logic [RW-1:0] rate,
  output logic [FW-1:0] cur_freq
);

  logic [RW-1:0]        tmr_q, tmr_n;
  logic [FW-1:0]        freq_n;
  logic signed [FW+1:0] sum;
  logic [FW-1:0]        clamped;
  logic                 step;

  always_comb begin
    sum = $signed({2'b00, cur_freq}) + $signed({{2{delta[FW-1]}}, delta});
    if (sum[FW+1])    clamped = '0;
    else if (sum[FW]) clamped = '1;
    else              clamped = sum[FW-1:0];

    step   = sweep && (tmr_q == rate);
    freq_n = cur_freq;
    tmr_n  = tmr_q;
    if (load) begin
      freq_n = load_ftw;
      tmr_n  = '0;
    end else if (sweep) begin
      if (step) begin
        freq_n = clamped;
        tmr_n  = '0;
      end else begin
        tmr_n = tmr_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_freq <= '0;
      tmr_q    <= '0;
    end else begin
      cur_freq <= freq_n;
      tmr_q    <= tmr_n;
    end
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FW = 32,
  parameter int TW = 15,
  parameter int OW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [FW-1:0] freq,
  input  logic [OW-1:0] poff,
  output logic [FW-1:0] phase_q,
  output logic [TW-1:0] pidx
);

  logic [FW-1:0] phase_n;

  always_comb begin
    phase_n = clr ? '0 : phase_q + freq;
    pidx    = phase_q[FW-1 -: TW] + {poff, {(TW-OW){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut
  import sweep_nco_pkg::*;
#(
  parameter int TW = 15,
  parameter int AW = 10,
  parameter int LW = 6,
  localparam int OQ   = TW - 2,
  localparam int FRW  = OQ - LW,
  localparam int MW   = AW - 1,
  localparam int N    = 1 << LW,
  localparam int HALF = 1 << (AW - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] pidx,
  output logic [AW-1:0] amp_q
);

  logic [MW-1:0]       rom [N+2];
  logic [1:0]          quad;
  logic [OQ:0]         off_m;
  logic [LW:0]         u;
  logic [FRW-1:0]      frac;
  logic [MW-1:0]       lo, hi, mag;
  logic [MW+FRW-1:0]   prod;
  logic [AW-1:0]       amp_n;

  for (genvar g = 0; g < N + 2; g++) begin : g_rom
    assign rom[g] = MW'(qsin_mag((g > N) ? N : g, N, HALF - 1));
  end

  always_comb begin
    quad  = pidx[TW-1 -: 2];
    off_m = quad[0] ? ((OQ+1)'(1 << OQ) - {1'b0, pidx[OQ-1:0]})
                    : {1'b0, pidx[OQ-1:0]};
    u     = off_m[OQ -: LW+1];
    frac  = off_m[FRW-1:0];
    lo    = rom[u];
    hi    = rom[u + (LW+1)'(1)];
    prod  = (hi - lo) * frac;
    mag   = lo + prod[MW+FRW-1 -: MW];
    amp_n = quad[1] ? AW'(HALF) - {1'b0, mag} : AW'(HALF) + {1'b0, mag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp_q <= AW'(HALF);
    else        amp_q <= amp_n;
  end

endmodule

// File: rtl/sweep_nco.sv
module sweep_nco #(
  parameter int NPROF = 4,
  parameter int FW    = 32,
  parameter int OW    = 14,
  parameter int RW    = 16,
  parameter int TW    = 15,
  parameter int AW    = 10,
  parameter int LW    = 6,
  localparam int SW   = $clog2(NPROF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prof_we,
  input  logic [SW-1:0] prof_idx,
  input  logic [FW-1:0] prof_ftw,
  input  logic [OW-1:0] prof_poff,
  input  logic          ramp_we,
  input  logic [FW-1:0] ramp_delta,
  input  logic [RW-1:0] ramp_rate,
  input  logic          ramp_en,
  input  logic [SW-1:0] prof_sel,
  input  logic          fud,
  input  logic          freq_clr,
  input  logic          phase_clr,
  output logic [FW-1:0] cur_freq,
  output logic [AW-1:0] amp_code
);

  logic [1:0]    rst_sync;
  logic          core_rst_n;
  logic [FW-1:0] load_ftw;
  logic [OW-1:0] act_poff_sel;
  logic [FW-1:0] act_delta;
  logic [RW-1:0] act_rate;
  logic          act_sweep;
  logic [SW-1:0] act_sel;
  logic [FW-1:0] phase_q;
  logic [TW-1:0] pidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  nco_prof_regs #(.NPROF(NPROF), .FW(FW), .OW(OW), .RW(RW)) i_regs (
    .clk, .rst_n(core_rst_n),
    .prof_we, .prof_idx, .prof_ftw, .prof_poff,
    .ramp_we, .ramp_delta, .ramp_rate, .ramp_en,
    .prof_sel, .fud,
    .load_ftw, .act_poff_sel, .act_delta, .act_rate, .act_sweep, .act_sel
  );

  nco_freq_ramp #(.FW(FW), .RW(RW)) i_ramp (
    .clk, .rst_n(core_rst_n),
    .load(fud | freq_clr), .load_ftw,
    .sweep(act_sweep), .delta(act_delta), .rate(act_rate),
    .cur_freq
  );

  nco_phase_acc #(.FW(FW), .TW(TW), .OW(OW)) i_phase (
    .clk, .rst_n(core_rst_n),
    .clr(phase_clr), .freq(cur_freq), .poff(act_poff_sel),
    .phase_q, .pidx
  );

  nco_sine_lut #(.TW(TW), .AW(AW), .LW(LW)) i_lut (
    .clk, .rst_n(core_rst_n),
    .pidx, .amp_q(amp_code)
  );

endmodule

// File: rtl/sweep_nco_chk.sv
module sweep_nco_chk #(
  parameter int FW = 32,
  parameter int AW = 10,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fud,
  input logic          freq_clr,
  input logic          phase_clr,
  input logic [SW-1:0] prof_sel,
  input logic [FW-1:0] cur_freq,
  input logic [AW-1:0] amp_code,
  input logic          act_sweep,
  input logic [FW-1:0] act_delta,
  input logic [SW-1:0] act_sel,
  input logic [FW-1:0] phase_q
);

  AST_SEL_ON_FUD: assert property (@(posedge clk) disable iff (!rst_n)
    fud |=> act_sel == $past(prof_sel)); // R2

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fud |=> $stable(act_sel)); // R2

  AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fud && !freq_clr && act_sweep && !act_delta[FW-1])
      |=> cur_freq >= $past(cur_freq)); // R7

  AST_DOWN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fud && !freq_clr && act_sweep && act_delta[FW-1])
      |=> cur_freq <= $past(cur_freq)); // R7

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fud && !freq_clr && !act_sweep) |=> $stable(cur_freq)); // R11

  AST_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> phase_q == '0); // R9

  AST_AMP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    amp_code != '0); // R10

endmodule

bind sweep_nco sweep_nco_chk #(.FW(FW), .AW(AW), .SW(SW)) i_chk (
  .clk, .rst_n, .fud, .freq_clr, .phase_clr, .prof_sel,
  .cur_freq, .amp_code, .act_sweep, .act_delta, .act_sel, .phase_q
);

// File: tb/test_sweep_nco.sv
module test_sweep_nco;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prof_we, ramp_we, ramp_en, fud, freq_clr, phase_clr;
  logic [1:0]  prof_idx, prof_sel;
  logic [31:0] prof_ftw, ramp_delta;
  logic [13:0] prof_poff;
  logic [15:0] ramp_rate;
  logic [31:0] cur_freq;
  logic [9:0]  amp_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] m_stg_ftw [4];
  logic [31:0] m_act_ftw [4];
  logic [13:0] m_stg_poff [4];
  logic [13:0] m_act_poff [4];
  logic [31:0] m_stg_dl, m_act_dl;
  logic [15:0] m_stg_rt, m_act_rt;
  logic        m_stg_en, m_act_en;
  logic [1:0]  m_sel;
  logic [31:0] m_f, m_ph;
  logic [15:0] m_t;
  int          m_amp;

  always #4 clk = ~clk;

  sweep_nco i_sweep_nco (
    .clk, .rst_n, .prof_we, .prof_idx, .prof_ftw, .prof_poff,
    .ramp_we, .ramp_delta, .ramp_rate, .ramp_en, .prof_sel,
    .fud, .freq_clr, .phase_clr, .cur_freq, .amp_code
  );

  function automatic int exp_amp(input logic [31:0] ph, input logic [13:0] po);
    logic [14:0] p;
    real r;
    p = ph[31:17] + {po, 1'b0};
    r = 511.0 * $sin(2.0 * 3.141592653589793 * real'(p) / 32768.0);
    return 512 + $rtoi($floor(r + 0.5));
  endfunction

  function automatic logic [31:0] clamp_add(input logic [31:0] f, input logic [31:0] d);
    logic signed [33:0] s;
    s = $signed({2'b00, f}) + $signed({{2{d[31]}}, d});
    if (s < 0) return 32'h0;
    if (s > 34'sh0_FFFF_FFFF) return 32'hFFFF_FFFF;
    return s[31:0];
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    logic [31:0] nf, nph, lftw;
    logic [15:0] nt;
    logic        ld;
    int          na;
    na   = exp_amp(m_ph, m_act_poff[m_sel]);
    nph  = phase_clr ? 32'h0 : m_ph + m_f;
    ld   = fud | freq_clr;
    lftw = fud ? m_stg_ftw[prof_sel] : m_act_ftw[m_sel];
    nf = m_f;
    nt = m_t;
    if (ld) begin
      nf = lftw;
      nt = 16'h0;
    end else if (m_act_en) begin
      if (m_t == m_act_rt) begin
        nf = clamp_add(m_f, m_act_dl);
        nt = 16'h0;
      end else nt = m_t + 16'h1;
    end
    if (fud) begin
      for (int k = 0; k < 4; k++) begin
        m_act_ftw[k]  = m_stg_ftw[k];
        m_act_poff[k] = m_stg_poff[k];
      end
      m_act_dl = m_stg_dl;
      m_act_rt = m_stg_rt;
      m_act_en = m_stg_en;
      m_sel    = prof_sel;
    end
    if (prof_we) begin
      m_stg_ftw[prof_idx]  = prof_ftw;
      m_stg_poff[prof_idx] = prof_poff;
    end
    if (ramp_we) begin
      m_stg_dl = ramp_delta;
      m_stg_rt = ramp_rate;
      m_stg_en = ramp_en;
    end
    m_f = nf; m_t = nt; m_ph = nph; m_amp = na;
  endtask

  task automatic step(input string tag);
    int d;
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(tag, "cur_freq", cur_freq, m_f);
    d = int'(amp_code) - m_amp;
    checks++;
    if (d > 2 || d < -2) begin
      failures++;
      $display("FAIL %s amp_code actual=%0d expected=%0d", tag, amp_code, m_amp);
    end
    prof_we = 0; ramp_we = 0; fud = 0; freq_clr = 0; phase_clr = 0;
  endtask

  task automatic wr_prof(input logic [1:0] i, input logic [31:0] f, input logic [13:0] po, input string tag);
    prof_we = 1; prof_idx = i; prof_ftw = f; prof_poff = po;
    step(tag);
  endtask

  task automatic wr_ramp(input logic [31:0] d, input logic [15:0] r, input logic en, input string tag);
    ramp_we = 1; ramp_delta = d; ramp_rate = r; ramp_en = en;
    step(tag);
  endtask

  task automatic strobe(input logic [1:0] sel, input string tag);
    fud = 1; prof_sel = sel;
    step(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(20240607);
    rst_n = 0;
    prof_we = 0; ramp_we = 0; ramp_en = 0; fud = 0; freq_clr = 0; phase_clr = 0;
    prof_idx = 0; prof_sel = 0; prof_ftw = 0; ramp_delta = 0; prof_poff = 0; ramp_rate = 0;
    for (int k = 0; k < 4; k++) begin
      m_stg_ftw[k] = 0; m_act_ftw[k] = 0; m_stg_poff[k] = 0; m_act_poff[k] = 0;
    end
    m_stg_dl = 0; m_act_dl = 0; m_stg_rt = 0; m_act_rt = 0; m_stg_en = 0; m_act_en = 0;
    m_sel = 0; m_f = 0; m_ph = 0; m_t = 0; m_amp = 512;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "cur_freq", cur_freq, 0);
    chk("R1", "amp_code", amp_code, 512);

    // R2: shadow writes and select changes stay invisible
    for (int k = 0; k < 4; k++)
      wr_prof(2'(k), 32'h0100_0000 * (k + 1), 14'(k * 'h300), "R2");
    wr_ramp(32'h0, 16'h0, 1'b0, "R2");
    prof_sel = 2'd2;
    step("R2");
    chk("R2", "cur_freq before fud", cur_freq, 0);
    strobe(2'd2, "R3");
    chk("R3", "cur_freq after fud", cur_freq, 32'h0300_0000);
    repeat (40) step("R4");

    // R3: write colliding with fud
    prof_we = 1; prof_idx = 2'd2; prof_ftw = 32'h0AAA_0000; prof_poff = 14'h0;
    strobe(2'd2, "R3");
    chk("R3", "collision keeps old word", cur_freq, 32'h0300_0000);
    strobe(2'd2, "R3");
    chk("R3", "second fud loads new word", cur_freq, 32'h0AAA_0000);

    // R5 / R10: quadrant starts with frozen phase
    wr_prof(2'd0, 32'h0, 14'h1000, "R5");
    fud = 1; prof_sel = 2'd0; phase_clr = 1;
    step("R5");
    step("R5");
    chk("R5", "quarter-turn offset", amp_code, 1023);
    wr_prof(2'd0, 32'h0, 14'h3000, "R10");
    strobe(2'd0, "R10");
    step("R10");
    chk("R10", "three-quarter offset", amp_code, 1);
    wr_prof(2'd0, 32'h0, 14'h2000, "R10");
    strobe(2'd0, "R10");
    step("R10");
    chk("R10", "half-turn offset", amp_code, 512);

    // R6: ramp interval
    wr_prof(2'd1, 32'h0001_0000, 14'h0, "R6");
    wr_ramp(32'h0000_1000, 16'd3, 1'b1, "R6");
    strobe(2'd1, "R6");
    repeat (8) step("R6");
    chk("R6", "two ramp steps", cur_freq, 32'h0001_2000);
    repeat (3) step("R6");

    // R8: restart from active word
    freq_clr = 1;
    step("R8");
    chk("R8", "freq_clr reload", cur_freq, 32'h0001_0000);
    repeat (5) step("R8");

    // R7: clamp at both ends
    wr_prof(2'd3, 32'hFFFF_FF00, 14'h0, "R7");
    wr_ramp(32'h0000_0040, 16'd1, 1'b1, "R7");
    strobe(2'd3, "R7");
    repeat (12) step("R7");
    chk("R7", "upper clamp", cur_freq, 32'hFFFF_FFFF);
    wr_prof(2'd3, 32'h0000_0100, 14'h0, "R7");
    wr_ramp(32'hFFFF_FFA0, 16'd0, 1'b1, "R7");
    strobe(2'd3, "R7");
    repeat (6) step("R7");
    chk("R7", "lower clamp", cur_freq, 32'h0);

    // R11: ramp disabled holds
    wr_prof(2'd3, 32'h0000_1234, 14'h0, "R11");
    wr_ramp(32'h0000_0100, 16'd0, 1'b0, "R11");
    strobe(2'd3, "R11");
    repeat (10) step("R11");
    chk("R11", "hold without ramp", cur_freq, 32'h0000_1234);

    // R9: phase clear
    wr_prof(2'd0, 32'h0100_0000, 14'h0, "R9");
    strobe(2'd0, "R9");
    repeat (5) step("R9");
    phase_clr = 1;
    step("R9");
    step("R9");
    chk("R9", "amp after phase clear", amp_code, 512);

    // random mix, includes ramp steps coinciding with loads
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 6 == 0) begin
        prof_we = 1; prof_idx = 2'($urandom); prof_ftw = $urandom; prof_poff = 14'($urandom);
      end
      if ($urandom % 10 == 0) begin
        ramp_we = 1;
        ramp_delta = 32'($signed($urandom % 32'h0200_0000) - 32'sh0100_0000);
        ramp_rate = 16'($urandom % 8); ramp_en = 1'($urandom);
      end
      prof_sel  = 2'($urandom);
      fud       = ($urandom % 8 == 0);
      freq_clr  = ($urandom % 30 == 0);
      phase_clr = ($urandom % 30 == 0);
      step("R4");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule